// File: doc/BRIEF.md
# Variable-Latency Pipeline Interlock Controller

This block is the hazard and sequencing control for an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) whose execute stage needs a different number of cycles depending on the operation class. It receives a stream of instruction descriptors. Each descriptor holds an operation class, a destination register and two source registers. Each cycle the block decides which stages move forward and where empty slots go. When an instruction starts execution, it also picks the source of each of its two operands: the register file, the memory-stage result or the writeback-stage result. No data, arithmetic or memory contents pass through the block.

A mode input selects between operand forwarding and a strict mode. In strict mode a dependent instruction stays in decode until its producer is in writeback. The register file writes in the first half of a cycle and reads in the second half, so a producer in writeback and a reader in decode may share a cycle. A cycle counter measures one program. Cycle 1 is the first cycle in which the first descriptor sits in fetch. The count freezes in the cycle the descriptor flagged as last sits in writeback. A testbench can therefore compare the count with totals worked out by hand for either mode.

The execute stage is tracked by a sequencer with three states:
- `EX_IDLE`: execute is empty.
- `EX_RUN`: a multi-cycle operation has more than one cycle left.
- `EX_FINAL`: the occupant leaves at the end of this cycle.

From `EX_IDLE` or `EX_FINAL`, an issue moves the sequencer to `EX_FINAL` for a one-cycle class or to `EX_RUN` for a longer one; with no issue it goes to `EX_IDLE`. `EX_RUN` counts down and then moves to `EX_FINAL`.

The program counter has three states:
- `CNT_IDLE`: after reset.
- `CNT_RUN`: a program is being measured.
- `CNT_DONE`: the result is frozen.

An accepted descriptor moves `CNT_IDLE` or `CNT_DONE` to `CNT_RUN` and loads 1. The last descriptor in writeback moves `CNT_RUN` to `CNT_DONE`.

Top module: `ilk_pipe_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1, and `id_hold`, `ex_busy`, `ex_issue`, `wb_valid`, `done`, `fwd_a`, `fwd_b` and `cycle_count` are all 0.
- R2: Operation class codes are ADD=0, SUB=1, MUL=2, DIV=3 and LOAD=4. Every stage except execute holds an instruction for one cycle. ADD, SUB and LOAD execute in one cycle. A lone single-cycle instruction therefore gives a count of 5, and N independent single-cycle instructions give N+4.
- R3: MUL occupies execute for 3 cycles and DIV for 6. During every cycle except the last, `ex_busy` is 1, no new issue follows, and fetch and decode hold their contents.
- R4: With forwarding on, an instruction in decode that reads the destination of a LOAD in execute waits exactly one extra cycle. It then issues with the operand source WB (code 2).
- R5: With forwarding on, on the issue cycle each operand takes MEM (code 1) if the memory stage holds its register, else WB (code 2) if writeback holds it, else register file (code 0). The memory stage wins over writeback. Both operands may be forwarded in the same cycle.
- R6: With forwarding off, an instruction whose source matches the destination of an instruction in execute or memory waits in decode. It may leave decode in the cycle its producer is in writeback. Both operand sources stay 0.
- R7: Register 0 means "no register": it never causes a wait and never selects a forwarded source. Inserted empty slots carry register 0.
- R8: `cycle_count` is 1 in the first cycle the first descriptor is in fetch and rises by one each cycle. It stops in the cycle the descriptor with `in_last` set is in writeback. `done` rises one cycle later, and the count then holds.
- R9: `ex_issue` is 1 only in the first execute cycle of each instruction, exactly once per instruction. `fwd_a` and `fwd_b` are 0 in all other cycles.
- R10: A descriptor accepted while `done` is 1 starts a new measurement, with the count at 1 in its fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1 = forwarding mode, 0 = wait-for-writeback mode |
| in_valid | input | 1 | A descriptor is offered |
| in_op | input | 3 | Operation class code |
| in_rd | input | REG_W (5) | Destination register, 0 = none |
| in_rs1 | input | REG_W (5) | First source register, 0 = none |
| in_rs2 | input | REG_W (5) | Second source register, 0 = none |
| in_last | input | 1 | Marks the final descriptor of a program |
| in_ready | output | 1 | Fetch accepts a descriptor at the next edge |
| id_hold | output | 1 | Decode holds an instruction this cycle |
| ex_busy | output | 1 | Execute stays occupied after this cycle |
| ex_issue | output | 1 | First execute cycle of an instruction |
| fwd_a | output | 2 | Source of the first operand: 0 register file, 1 MEM, 2 WB |
| fwd_b | output | 2 | Source of the second operand, same codes |
| wb_valid | output | 1 | Writeback holds an instruction |
| wb_rd | output | REG_W (5) | Destination register in writeback |
| cycle_count | output | CNT_W (16) | Cycles of the current or last program |
| done | output | 1 | The measurement is complete |

## Verification
A wrong sequencer count shows at the ports within the instruction that caused it. `ex_busy` stays high for the wrong number of cycles, and the next `ex_issue` lands on the wrong count value. A missed or extra stall shifts every later issue cycle and the final total. A wrong forwarding choice shows on `fwd_a` or `fwd_b` on the very issue cycle of the consumer. A counter that fails to stop or to restart shows in the first cycle after the last writeback, or in the fetch cycle of the next program.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int unsigned REG_W = 5;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_LOAD = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } src_e;

    typedef struct packed {
        logic             vld;
        op_e              op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic             last;
    } slot_t;

endpackage

// File: rtl/ilk_hazard.sv
module ilk_hazard
    import ilk_pkg::*;
(
    input  logic             fwd_en,
    input  logic             id_vld,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             ex_vld,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_vld,
    input  logic [REG_W-1:0] mem_rd,
    output logic             hazard
);

    logic ex_hit;
    logic mem_hit;

    // a producer slot matches when it writes a real register read by decode
    always_comb begin
        ex_hit  = ex_vld && (ex_rd != '0) &&
                  ((id_rs1 == ex_rd) || (id_rs2 == ex_rd));
        mem_hit = mem_vld && (mem_rd != '0) &&
                  ((id_rs1 == mem_rd) || (id_rs2 == mem_rd));
    end

    always_comb begin
        if (fwd_en) begin
            // only a load result comes too late for the memory-stage path
            hazard = id_vld && ex_is_load && ex_hit;
        end else begin
            // strict mode: wait until the producer has reached writeback
            hazard = id_vld && (ex_hit || mem_hit);
        end
    end

endmodule

// File: rtl/ilk_fwd.sv
module ilk_fwd
    import ilk_pkg::*;
#(
    parameter int unsigned NSRC = 2
) (
    input  logic             fwd_en,
    input  logic             ex_first,
    input  logic [REG_W-1:0] ex_src [NSRC],
    input  logic             mem_vld,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             wb_vld,
    input  logic [REG_W-1:0] wb_rd,
    output src_e             sel [NSRC]
);

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        always_comb begin
            sel[g] = SRC_RF;
            if (fwd_en && ex_first && (ex_src[g] != '0)) begin
                // the younger result in memory outranks writeback
                if (mem_vld && (mem_rd == ex_src[g])) begin
                    sel[g] = SRC_MEM;
                end else if (wb_vld && (wb_rd == ex_src[g])) begin
                    sel[g] = SRC_WB;
                end
            end
        end
    end

endmodule

// File: rtl/ilk_ex_seq.sv
module ilk_ex_seq
    import ilk_pkg::*;
#(
    parameter int unsigned LAT_MUL = 3,
    parameter int unsigned LAT_DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  op_e  op,
    output logic ex_done
);

    localparam int unsigned MAX_LAT = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int unsigned CW      = $clog2(MAX_LAT) + 1;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_RUN,
        EX_FINAL
    } ex_state_e;

    ex_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [CW-1:0]  lat_v;

    always_comb begin
        unique case (op)
            OP_MUL:  lat_v = CW'(LAT_MUL);
            OP_DIV:  lat_v = CW'(LAT_DIV);
            default: lat_v = CW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            EX_IDLE, EX_FINAL: begin
                if (issue) begin
                    if (lat_v <= CW'(1)) begin
                        state_d = EX_FINAL;
                    end else begin
                        state_d = EX_RUN;
                        cnt_d   = lat_v - CW'(2);
                    end
                end else begin
                    state_d = EX_IDLE;
                end
            end
            EX_RUN: begin
                if (cnt_q == '0) begin
                    state_d = EX_FINAL;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: state_d = EX_IDLE;
        endcase
    end

    always_comb begin
        ex_done = (state_q != EX_RUN);
    end

endmodule

// File: rtl/ilk_cyc_fsm.sv
module ilk_cyc_fsm #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             finish,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    typedef enum logic [1:0] {
        CNT_IDLE,
        CNT_RUN,
        CNT_DONE
    } cnt_state_e;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CNT_IDLE, CNT_DONE: begin
                if (start) begin
                    state_d = CNT_RUN;
                    cnt_d   = CNT_W'(1);
                end
            end
            CNT_RUN: begin
                if (finish) begin
                    state_d = CNT_DONE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = CNT_IDLE;
        endcase
    end

    always_comb begin
        count = cnt_q;
        done  = (state_q == CNT_DONE);
    end

endmodule

// File: rtl/ilk_pipe_ctrl.sv
module ilk_pipe_ctrl
    import ilk_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned LAT_MUL = 3,
    parameter int unsigned LAT_DIV = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [REG_W-1:0] in_rd,
    input  logic [REG_W-1:0] in_rs1,
    input  logic [REG_W-1:0] in_rs2,
    input  logic             in_last,
    output logic             in_ready,
    output logic             id_hold,
    output logic             ex_busy,
    output logic             ex_issue,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_rd,
    output logic [CNT_W-1:0] cycle_count,
    output logic             done
);

    localparam int unsigned NSRC = 2;

    slot_t if_s, id_s, ex_s, mem_s, wb_s;
    slot_t in_s;
    logic  ex_first_q;
    logic  ex_done;
    logic  hazard;
    logic  id_go;
    logic  if_go;
    logic  accept;

    logic [REG_W-1:0] ex_src [NSRC];
    src_e             sel    [NSRC];

    always_comb begin
        in_s.vld  = 1'b1;
        in_s.op   = op_e'(in_op);
        in_s.rd   = in_rd;
        in_s.rs1  = in_rs1;
        in_s.rs2  = in_rs2;
        in_s.last = in_last;
    end

    ilk_hazard u_haz (
        .fwd_en     (fwd_en),
        .id_vld     (id_s.vld),
        .id_rs1     (id_s.rs1),
        .id_rs2     (id_s.rs2),
        .ex_vld     (ex_s.vld),
        .ex_is_load (ex_s.op == OP_LOAD),
        .ex_rd      (ex_s.rd),
        .mem_vld    (mem_s.vld),
        .mem_rd     (mem_s.rd),
        .hazard     (hazard)
    );

    always_comb begin
        id_go    = id_s.vld && ex_done && !hazard;
        if_go    = if_s.vld && (!id_s.vld || id_go);
        in_ready = !if_s.vld || if_go;
        accept   = in_valid && in_ready;
    end

    ilk_ex_seq #(
        .LAT_MUL (LAT_MUL),
        .LAT_DIV (LAT_DIV)
    ) u_exseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (id_go),
        .op      (id_s.op),
        .ex_done (ex_done)
    );

    // stage registers: later stages always advance, earlier ones may hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_s       <= '0;
            id_s       <= '0;
            ex_s       <= '0;
            mem_s      <= '0;
            wb_s       <= '0;
            ex_first_q <= 1'b0;
        end else begin
            wb_s       <= mem_s;
            mem_s      <= ex_done ? ex_s : '0;
            ex_first_q <= id_go;
            if (ex_done) begin
                ex_s <= id_go ? id_s : '0;
            end
            if (!id_s.vld || id_go) begin
                id_s <= if_go ? if_s : '0;
            end
            if (in_ready) begin
                if_s <= accept ? in_s : '0;
            end
        end
    end

    always_comb begin
        ex_src[0] = ex_s.rs1;
        ex_src[1] = ex_s.rs2;
    end

    ilk_fwd #(
        .NSRC (NSRC)
    ) u_fwd (
        .fwd_en   (fwd_en),
        .ex_first (ex_first_q),
        .ex_src   (ex_src),
        .mem_vld  (mem_s.vld),
        .mem_rd   (mem_s.rd),
        .wb_vld   (wb_s.vld),
        .wb_rd    (wb_s.rd),
        .sel      (sel)
    );

    ilk_cyc_fsm #(
        .CNT_W (CNT_W)
    ) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .finish (wb_s.vld && wb_s.last),
        .count  (cycle_count),
        .done   (done)
    );

    always_comb begin
        id_hold  = id_s.vld && !id_go;
        ex_busy  = !ex_done;
        ex_issue = ex_first_q;
        fwd_a    = sel[0];
        fwd_b    = sel[1];
        wb_valid = wb_s.vld;
        wb_rd    = wb_s.rd;
    end

endmodule

// File: rtl/ilk_chk.sv
module ilk_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fwd_en,
    input logic             in_valid,
    input logic             in_ready,
    input logic             id_hold,
    input logic             ex_busy,
    input logic             ex_issue,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic [CNT_W-1:0] cycle_count,
    input logic             done
);

    // R6
    strict_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> (fwd_a == 2'd0 && fwd_b == 2'd0));

    // R9
    quiet_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_issue |-> (fwd_a == 2'd0 && fwd_b == 2'd0));

    // R5
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'd3) && (fwd_b != 2'd3));

    // R3
    busy_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_busy |=> !ex_issue);

    // R3
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> id_hold);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && cycle_count != '0) |=>
            ((cycle_count == $past(cycle_count) + 1'b1) ||
             (done && cycle_count == $past(cycle_count))));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(in_valid && in_ready)) |=> (done && $stable(cycle_count)));

endmodule

bind ilk_pipe_ctrl ilk_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_ilk_pipe_ctrl.sv
module sim_ilk_pipe_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int MAXN       = 16;
    localparam int L_MUL      = 3;
    localparam int L_DIV      = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fwd_en;
    logic             in_valid;
    logic [2:0]       in_op;
    logic [4:0]       in_rd, in_rs1, in_rs2;
    logic             in_last;
    logic             in_ready, id_hold, ex_busy, ex_issue;
    logic [1:0]       fwd_a, fwd_b;
    logic             wb_valid;
    logic [4:0]       wb_rd;
    logic [CNT_W-1:0] cycle_count;
    logic             done;

    int n_checks = 0;
    int n_errors = 0;
    bit summary_done = 0;

    int p_op [MAXN], p_rd [MAXN], p_rs1 [MAXN], p_rs2 [MAXN];
    int d_t [MAXN], e_t [MAXN], m_t [MAXN], w_t [MAXN];
    int fa_x [MAXN], fb_x [MAXN];
    int busy_x;
    int last_total;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilk_pipe_ctrl #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .in_valid(in_valid),
        .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_last(in_last), .in_ready(in_ready), .id_hold(id_hold),
        .ex_busy(ex_busy), .ex_issue(ex_issue), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .wb_valid(wb_valid), .wb_rd(wb_rd), .cycle_count(cycle_count),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lat(input int op);
        if (op == 2) return L_MUL;
        if (op == 3) return L_DIV;
        return 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int src_sel(input int i, input int rs, input bit fw);
        if (!fw || rs == 0) return 0;
        for (int j = i - 1; j >= 0; j--) begin
            if (p_rd[j] == rs) begin
                if (m_t[j] == e_t[i]) return 1;
                if (w_t[j] == e_t[i]) return 2;
                return 0;
            end
        end
        return 0;
    endfunction

    // schedule: cycle in which each instruction enters decode, execute, memory, writeback
    task automatic model(input int n, input bit fw);
        busy_x = 0;
        for (int i = 0; i < n; i++) begin
            int f, d, e;
            f = (i == 0) ? 1 : d_t[i-1];
            d = (i == 0) ? 2 : imax(f + 1, e_t[i-1]);
            e = d + 1;
            if (i > 0) e = imax(e, e_t[i-1] + lat(p_op[i-1]));
            for (int j = 0; j < i; j++) begin
                if (p_rd[j] != 0 && (p_rs1[i] == p_rd[j] || p_rs2[i] == p_rd[j])) begin
                    if (fw) e = imax(e, (p_op[j] == 4) ? w_t[j] : m_t[j]);
                    else    e = imax(e, w_t[j] + 1);
                end
            end
            d_t[i] = d;
            e_t[i] = e;
            m_t[i] = e + lat(p_op[i]);
            w_t[i] = m_t[i] + 1;
            busy_x += lat(p_op[i]) - 1;
        end
        for (int i = 0; i < n; i++) begin
            fa_x[i] = src_sel(i, p_rs1[i], fw);
            fb_x[i] = src_sel(i, p_rs2[i], fw);
        end
    endtask

    task automatic setp(input int i, input int op, input int rd, input int a, input int b);
        p_op[i] = op; p_rd[i] = rd; p_rs1[i] = a; p_rs2[i] = b;
    endtask

    task automatic run_prog(input int n, input bit fw);
        int idx = 0;
        int k = 0;
        int busy_cnt = 0;
        int guard = 0;
        bit fin = 0;
        model(n, fw);
        @(negedge clk);
        fwd_en = fw;
        while (!fin) begin
            if (ex_busy) busy_cnt++;
            if (ex_issue) begin
                if (k < n) begin
                    // R2 R3 R4 R6: issue cycle follows the schedule
                    check(int'(cycle_count) == e_t[k], "R2/R3 issue cycle", int'(cycle_count), e_t[k]);
                    // R5 R4 R7: operand sources on the issue cycle
                    check(int'(fwd_a) == fa_x[k], "R5 operand a source", int'(fwd_a), fa_x[k]);
                    check(int'(fwd_b) == fb_x[k], "R5 operand b source", int'(fwd_b), fb_x[k]);
                end
                k++;
            end
            if (done && idx == n) begin
                fin = 1;
            end else if (idx < n) begin
                in_valid = 1'b1;
                in_op    = 3'(p_op[idx]);
                in_rd    = 5'(p_rd[idx]);
                in_rs1   = 5'(p_rs1[idx]);
                in_rs2   = 5'(p_rs2[idx]);
                in_last  = (idx == n - 1);
                if (in_ready) idx++;
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            guard++;
            if (guard > 3000) begin
                check(1'b0, "R8 program watchdog", guard, 0);
                fin = 1;
            end
            if (!fin) @(negedge clk);
        end
        in_valid = 1'b0;
        last_total = int'(cycle_count);
        // R8: frozen total equals the last writeback cycle
        check(last_total == w_t[n-1], "R8 total cycles", last_total, w_t[n-1]);
        // R9: one issue pulse per instruction
        check(k == n, "R9 issue pulses", k, n);
        // R3: cycles with execute held
        check(busy_cnt == busy_x, "R3 busy cycles", busy_cnt, busy_x);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!summary_done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary_done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A7C));
        rst_n = 1'b0; fwd_en = 1'b1; in_valid = 1'b0; in_op = '0;
        in_rd = '0; in_rs1 = '0; in_rs2 = '0; in_last = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(!ex_issue && !ex_busy && !id_hold, "R1 pipe idle", int'({ex_issue, ex_busy, id_hold}), 0);
        check(!wb_valid && !done, "R1 wb/done", int'({wb_valid, done}), 0);
        check(cycle_count == 0 && fwd_a == 0 && fwd_b == 0, "R1 count/sel", int'(cycle_count), 0);

        // R2: lone ADD
        setp(0, 0, 1, 2, 3);
        run_prog(1, 1'b1);
        check(last_total == 5, "R2 lone add", last_total, 5);

        // R2: four independent single-cycle ops; R10 restart after done
        setp(0, 0, 1, 2, 3); setp(1, 1, 4, 5, 6); setp(2, 0, 7, 2, 3); setp(3, 1, 8, 5, 6);
        run_prog(4, 1'b1);
        check(last_total == 8, "R10 restart count", last_total, 8);

        // R4: load then use of both operands
        setp(0, 4, 1, 2, 0); setp(1, 0, 2, 1, 1);
        run_prog(2, 1'b1);
        check(last_total == 7, "R4 load-use total", last_total, 7);
        check(fa_x[1] == 2 && fb_x[1] == 2, "R4 expect WB both", fa_x[1], 2);

        // R5: memory stage outranks writeback
        setp(0, 0, 3, 1, 2); setp(1, 0, 3, 1, 2); setp(2, 1, 4, 3, 0);
        run_prog(3, 1'b1);
        check(fa_x[2] == 1, "R5 priority expect", fa_x[2], 1);

        // R3 R5: multi-cycle sequence with forwarding
        setp(0, 2, 2, 0, 1); setp(1, 3, 5, 3, 4); setp(2, 0, 2, 5, 2); setp(3, 1, 5, 2, 6);
        run_prog(4, 1'b1);
        check(last_total == 15, "R3 mul/div forwarded total", last_total, 15);

        // R6: same sequence, strict mode
        run_prog(4, 1'b0);
        check(last_total == 19, "R6 strict total", last_total, 19);

        // R7: register 0 never forms a dependency
        setp(0, 0, 0, 1, 2); setp(1, 0, 5, 0, 0);
        run_prog(2, 1'b0);
        check(last_total == 6, "R7 zero register", last_total, 6);

        // random programs in both modes
        for (int r = 0; r < 12; r++) begin
            int n = 6 + int'($urandom % 7);
            for (int i = 0; i < n; i++)
                setp(i, int'($urandom % 5), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
            run_prog(n, 1'($urandom % 2));
        end

        if (!summary_done) begin
            summary_done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule